// File: doc/BRIEF.md
# Flash Control Register Unlock Guard

This block stands between a register bus and the two flash control registers, one for each processor. Out of reset, both control registers are closed to writes. Software opens them by writing two fixed key words, in a fixed order, to a key register. A successful sequence opens both control registers at once. Any deviation from that sequence closes the guard for good, and only a system reset reopens it. Each bad key write returns a bus error and pulses a fault output. Software can close each control register again by setting its LOCK bit. After that, a new pair of keys is needed.

The block also holds the busy flag of a flash operation. A START bit written to an open control register sets the flag, and a done input from the flash side clears it. While the flag is set, read requests to the flash array see their ready signal held low. They complete once the operation has finished.

The register map uses word offsets. The key register is at offset 0, the first control register at 1, the second at 2, and a read-only status register at 3. In a control register, bit 0 is LOCK, bit 1 is START (write-only, reads 0), bit 2 is BUSY (read-only) and bits [15:8] hold an 8-bit configuration field. In the status register, bit 0 is the permanent lockout and bit 1 is BUSY. Every register access gets its response one cycle later: read data on `bus_rdata_o`, and for writes an error flag on `bus_err_o`.

Top module: `flash_ctl_guard`

## Requirements
- R1: After reset both control registers read 0x00000001 (LOCK=1, configuration 0), the status register reads 0 and no operation is busy.
- R2: Writing 0x45670123 to offset 0 and then 0xCDEF89AB to offset 0, with both registers locked and no lockout, clears LOCK in both control registers. Neither key write returns an error.
- R3: Any other value in either key position sets the permanent lockout (status bit 0). After that, no key writes unlock the registers again until reset.
- R4: Each wrong key write returns `bus_err_o`=1 in its response cycle and pulses `fault_o` in that same cycle only.
- R5: Writing 1 to LOCK of an open control register closes that register alone. A fresh two-key sequence opens it again.
- R6: A key write while either control register is open counts as a wrong sequence. It triggers the lockout and closes both registers.
- R7: A write to a locked control register changes no state (configuration, LOCK, busy). With the default parameter it returns no error.
- R8: The key register reads as 0.
- R9: LOCK cannot be cleared by writing 0 to it; only the key sequence clears it.
- R10: Writing 1 to START (bit 1) of an open control register sets BUSY (control bit 2, status bit 1). A pulse on `op_done_i` clears it.
- R11: While BUSY is set, `arr_rdy_o` stays 0 for a pending array read. It goes back to 1 once the operation is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low system reset |
| bus_addr_i | input | 4 | Register word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, one cycle after the read |
| bus_err_o | output | 1 | Error response, one cycle after the access |
| fault_o | output | 1 | Fault pulse for a wrong key write |
| arr_rd_i | input | 1 | Flash array read request |
| arr_rdy_o | output | 1 | Array read may complete |
| op_done_i | input | 1 | Flash operation finished |

## Verification
The in-line assertions check the following on every cycle:
- the lockout never falls once set;
- a locked register stays locked unless the second key is written at that moment;
- a dropped write leaves the configuration untouched;
- a fault pulse always comes with a bus error;
- BUSY holds until done arrives.

Only the bench scenarios can show the rest: the exact read values after each sequence, the single-cycle shape of the fault, the difference between a wrong first key, a wrong second key and a key written while open, and the stall released by done.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

    localparam int unsigned OFS_KEY  = 0;
    localparam int unsigned OFS_CTL0 = 1;
    localparam int unsigned OFS_CTL1 = 2;
    localparam int unsigned OFS_STAT = 3;

    localparam int unsigned LOCK_BIT  = 0;
    localparam int unsigned START_BIT = 1;
    localparam int unsigned BUSY_BIT  = 2;
    localparam int unsigned CFG_LSB   = 8;

    localparam int unsigned STAT_DEAD_BIT = 0;
    localparam int unsigned STAT_BUSY_BIT = 1;

    typedef enum logic [1:0] {
        SEQ_WAIT1 = 2'd0,
        SEQ_WAIT2 = 2'd1,
        SEQ_DEAD  = 2'd2
    } seq_e;
endpackage

// File: rtl/fcg_key_seq.sv
module fcg_key_seq
    import fcg_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          key_we_i,
    input  logic [DW-1:0] key_data_i,
    input  logic          any_open_i,
    output logic          unlock_o,
    output logic          bad_o,
    output logic          dead_o
);
    typedef struct packed {
        seq_e st;
    } seq_state_t;

    seq_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        unlock_o = 1'b0;
        bad_o    = 1'b0;
        if (key_we_i) begin
            unique case (cur_q.st)
                SEQ_WAIT1: begin
                    if (!any_open_i && key_data_i == DW'(KEY_FIRST)) begin
                        nxt_d.st = SEQ_WAIT2;
                    end else begin
                        nxt_d.st = SEQ_DEAD;
                        bad_o    = 1'b1;
                    end
                end
                SEQ_WAIT2: begin
                    if (!any_open_i && key_data_i == DW'(KEY_SECOND)) begin
                        nxt_d.st = SEQ_WAIT1;
                        unlock_o = 1'b1;
                    end else begin
                        nxt_d.st = SEQ_DEAD;
                        bad_o    = 1'b1;
                    end
                end
                default: bad_o = 1'b1;
            endcase
        end
        dead_o = (cur_q.st == SEQ_DEAD);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '{st: SEQ_WAIT1};
        else         cur_q <= nxt_d;
    end

    assert_lockout_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dead_o |=> dead_o);
endmodule

// File: rtl/fcg_ctl_reg.sv
module fcg_ctl_reg
    import fcg_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned CFG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             unlock_i,
    input  logic             kill_i,
    output logic             locked_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             start_o,
    output logic             drop_o
);
    typedef struct packed {
        logic             locked;
        logic [CFG_W-1:0] cfg;
    } ctl_state_t;

    ctl_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d   = cur_q;
        start_o = 1'b0;
        drop_o  = 1'b0;
        if (wr_i) begin
            if (cur_q.locked) begin
                drop_o = 1'b1;
            end else begin
                nxt_d.cfg = wdata_i[CFG_LSB +: CFG_W];
                if (wdata_i[LOCK_BIT]) nxt_d.locked = 1'b1;
                start_o = wdata_i[START_BIT];
            end
        end
        if (unlock_i) nxt_d.locked = 1'b0;
        if (kill_i)   nxt_d.locked = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '{locked: 1'b1, cfg: '0};
        else         cur_q <= nxt_d;
    end

    assign locked_o = cur_q.locked;
    assign cfg_o    = cur_q.cfg;

    assert_lock_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && !unlock_i) |=> locked_o);
    assert_locked_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && locked_o) |=> $stable(cfg_o));
endmodule

// File: rtl/flash_ctl_guard.sv
module flash_ctl_guard
    import fcg_pkg::*;
#(
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned DW            = 32,
    parameter int unsigned CFG_W         = 8,
    parameter bit          LOCKED_WR_ERR = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              bus_err_o,
    output logic              fault_o,
    input  logic              arr_rd_i,
    output logic              arr_rdy_o,
    input  logic              op_done_i
);
    localparam int unsigned N_CTL = 2;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          err;
        logic          fault;
        logic          busy;
    } top_state_t;

    top_state_t cur_q, nxt_d;

    logic             sel_key, sel_stat;
    logic [N_CTL-1:0] sel_ctl;
    logic [N_CTL-1:0] locked, start, drop;
    logic [CFG_W-1:0] cfg [N_CTL];
    logic             seq_unlock, seq_bad, seq_dead;

    assign sel_key  = (bus_addr_i == ADDR_W'(OFS_KEY));
    assign sel_stat = (bus_addr_i == ADDR_W'(OFS_STAT));
    assign sel_ctl  = {bus_addr_i == ADDR_W'(OFS_CTL1), bus_addr_i == ADDR_W'(OFS_CTL0)};

    fcg_key_seq #(.DW(DW)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .key_we_i   (bus_we_i && sel_key),
        .key_data_i (bus_wdata_i),
        .any_open_i (~&locked),
        .unlock_o   (seq_unlock),
        .bad_o      (seq_bad),
        .dead_o     (seq_dead)
    );

    for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
        fcg_ctl_reg #(.DW(DW), .CFG_W(CFG_W)) u_ctl (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .wr_i     (bus_we_i && sel_ctl[g]),
            .wdata_i  (bus_wdata_i),
            .unlock_i (seq_unlock),
            .kill_i   (seq_bad),
            .locked_o (locked[g]),
            .cfg_o    (cfg[g]),
            .start_o  (start[g]),
            .drop_o   (drop[g])
        );
    end

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.rdata = '0;
        nxt_d.fault = seq_bad;
        nxt_d.err   = seq_bad || (LOCKED_WR_ERR && (|drop));
        if (|start)         nxt_d.busy = 1'b1;
        else if (op_done_i) nxt_d.busy = 1'b0;
        if (bus_re_i) begin
            if (sel_stat) begin
                nxt_d.rdata[STAT_DEAD_BIT] = seq_dead;
                nxt_d.rdata[STAT_BUSY_BIT] = cur_q.busy;
            end
            for (int i = 0; i < N_CTL; i++) begin
                if (sel_ctl[i]) begin
                    nxt_d.rdata[LOCK_BIT]           = locked[i];
                    nxt_d.rdata[BUSY_BIT]           = cur_q.busy;
                    nxt_d.rdata[CFG_LSB +: CFG_W]   = cfg[i];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign bus_rdata_o = cur_q.rdata;
    assign bus_err_o   = cur_q.err;
    assign fault_o     = cur_q.fault;
    assign arr_rdy_o   = arr_rd_i && !cur_q.busy;

    assert_unlock_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_unlock |-> (bus_we_i && sel_key && bus_wdata_i == DW'(KEY_SECOND)));
    assert_fault_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> bus_err_o);
    assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.busy && !op_done_i) |=> cur_q.busy);
endmodule

// File: tb/flash_ctl_guard_tb.sv
`timescale 1ns/1ps
module flash_ctl_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0, re = 1'b0, arr_rd = 1'b0, done = 1'b0;
    logic [31:0] rdata;
    logic        err, fault, arr_rdy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic        is_rd;
        logic [31:0] data;
        logic        err;
        logic        fault;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic  acc_seen = 1'b0;

    localparam logic [31:0] K1 = 32'h4567_0123;
    localparam logic [31:0] K2 = 32'hCDEF_89AB;

    always #2.5 clk = ~clk;

    flash_ctl_guard u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_we_i(we), .bus_re_i(re), .bus_rdata_o(rdata), .bus_err_o(err),
        .fault_o(fault), .arr_rd_i(arr_rd), .arr_rdy_o(arr_rdy), .op_done_i(done)
    );

    always @(posedge clk) acc_seen <= rst_n && (we || re);

    // monitor: compares each registered response against the scoreboard
    always @(negedge clk) begin
        if (acc_seen && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (err !== e.err || fault !== e.fault ||
                (e.is_rd && rdata !== e.data)) begin
                bad++;
                $display("FAIL %s: rdata=%h err=%b fault=%b expected rdata=%h err=%b fault=%b",
                         t, rdata, err, fault, e.data, e.err, e.fault);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d,
                      input logic e_err, input logic e_fault, input string t);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1; re = 1'b0;
        exp_q.push_back('{is_rd: 1'b0, data: '0, err: e_err, fault: e_fault});
        tag_q.push_back(t);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] d, input string t);
        @(negedge clk);
        addr = a; re = 1'b1; we = 1'b0;
        exp_q.push_back('{is_rd: 1'b1, data: d, err: 1'b0, fault: 1'b0});
        tag_q.push_back(t);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic chk(input logic act, input logic expv, input string t);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", t, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state, R8 key reads zero
        rd(4'd1, 32'h1, "R1 ctl0 reset");
        rd(4'd2, 32'h1, "R1 ctl1 reset");
        rd(4'd3, 32'h0, "R1 stat reset");
        rd(4'd0, 32'h0, "R8 key reads zero");
        // R7 write to locked register dropped, no error
        wr(4'd1, 32'h0000_AB02, 1'b0, 1'b0, "R7 locked write no err");
        rd(4'd1, 32'h1, "R7 ctl0 unchanged");
        rd(4'd3, 32'h0, "R7 no busy from locked start");
        // R2 unlock
        wr(4'd0, K1, 1'b0, 1'b0, "R2 key1");
        wr(4'd0, K2, 1'b0, 1'b0, "R2 key2");
        rd(4'd1, 32'h0, "R2 ctl0 open");
        rd(4'd2, 32'h0, "R2 ctl1 open");
        rd(4'd0, 32'h0, "R8 key reads zero after unlock");
        wr(4'd1, 32'h0000_5A00, 1'b0, 1'b0, "R9 write lock0 open");
        rd(4'd1, 32'h0000_5A00, "R9 lock stays clear with cfg");
        // R10 start and busy, R11 stall
        wr(4'd2, 32'h0000_3C02, 1'b0, 1'b0, "R10 start");
        rd(4'd3, 32'h2, "R10 stat busy");
        rd(4'd2, 32'h0000_3C04, "R10 ctl1 busy bit");
        @(negedge clk); arr_rd = 1'b1;
        #1 chk(arr_rdy, 1'b0, "R11 array read stalled");
        @(negedge clk); chk(arr_rdy, 1'b0, "R11 still stalled");
        done = 1'b1;
        @(negedge clk); done = 1'b0;
        #1 chk(arr_rdy, 1'b1, "R11 read completes after done");
        @(negedge clk); arr_rd = 1'b0;
        rd(4'd3, 32'h0, "R10 busy cleared");
        // R5 relock each register
        wr(4'd1, 32'h0000_5A01, 1'b0, 1'b0, "R5 relock ctl0");
        rd(4'd1, 32'h0000_5A01, "R5 ctl0 locked");
        rd(4'd2, 32'h0000_3C00, "R5 ctl1 still open");
        wr(4'd2, 32'h0000_0001, 1'b0, 1'b0, "R5 relock ctl1");
        rd(4'd2, 32'h0000_0001, "R5 ctl1 locked");
        wr(4'd1, 32'h0000_0000, 1'b0, 1'b0, "R9 write lock0 locked");
        rd(4'd1, 32'h0000_5A01, "R9 lock still set");
        wr(4'd0, K1, 1'b0, 1'b0, "R5 fresh key1");
        wr(4'd0, K2, 1'b0, 1'b0, "R5 fresh key2");
        rd(4'd1, 32'h0000_5A00, "R5 ctl0 reopened");
        // R6 key write while open
        wr(4'd0, K1, 1'b1, 1'b1, "R6 key while open");
        @(negedge clk); chk(fault, 1'b0, "R4 fault single cycle");
        rd(4'd3, 32'h1, "R6 lockout set");
        rd(4'd1, 32'h0000_5A01, "R6 ctl0 closed");
        rd(4'd2, 32'h0000_0001, "R6 ctl1 closed");
        wr(4'd0, K1, 1'b1, 1'b1, "R3 key1 after lockout");
        wr(4'd0, K2, 1'b1, 1'b1, "R3 key2 after lockout");
        rd(4'd1, 32'h0000_5A01, "R3 no recovery");
        // wrong second key
        do_reset();
        rd(4'd3, 32'h0, "R1 stat after second reset");
        wr(4'd0, K1, 1'b0, 1'b0, "R3 key1 good");
        wr(4'd0, 32'h1234_5678, 1'b1, 1'b1, "R4 wrong second key");
        rd(4'd3, 32'h1, "R3 lockout after wrong second");
        wr(4'd0, K1, 1'b1, 1'b1, "R3 retry key1");
        wr(4'd0, K2, 1'b1, 1'b1, "R3 retry key2");
        rd(4'd2, 32'h1, "R3 ctl1 still locked");
        // wrong first key
        do_reset();
        wr(4'd0, K2, 1'b1, 1'b1, "R4 wrong first key");
        @(negedge clk); chk(err, 1'b0, "R4 err single cycle");
        rd(4'd3, 32'h1, "R3 lockout after wrong first");
        wr(4'd1, 32'h0000_7702, 1'b0, 1'b0, "R7 write after lockout");
        rd(4'd1, 32'h1, "R7 ctl0 untouched");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule